// File: doc/BRIEF.md
# IDE PIO Cycle Timing Controller

This block sits between a host I/O port and a legacy IDE channel. It decides whether a host I/O address belongs to the channel, and for each access it claims it produces a timed read or write command strobe. One 16-bit control word sets everything. It selects which legacy channel is decoded. It sets, for each of the two drives, whether fast timing applies and whether a programmable IORDY sample point is used. It also holds a sample-point code and a recovery code.

A requester presents an address, a direction and a drive number with a valid flag, and holds them until a clock edge at which `hit` is high and `busy` is low. The strobe opens on the next cycle. IORDY is sampled at the programmed clock of the strobe. A low IORDY stretches the strobe until it returns high. Closing the strobe raises `done` for one cycle and starts a recovery gap, during which `busy` stays high and new requests wait.

Top module: `ide_pio_timer`

## Requirements
- R1: With channel field ctrl[1:0] = 00 or 11, no address gives `hit`, and no strobe starts.
- R2: With ctrl[1:0] = 01, `hit` is high exactly for a valid request at 0x1F0 to 0x1F7, 0x3F6 or 0x3F7.
- R3: With ctrl[1:0] = 10, `hit` is high exactly for a valid request at 0x170 to 0x17F, 0x376 or 0x377.
- R4: A drive whose fast bit is clear (ctrl[2] for drive 0, ctrl[3] for drive 1) holds the strobe 6 clocks and recovers 8 clocks, whatever the codes say.
- R5: When a drive has both its fast bit and its sample-enable bit set (ctrl[4] for drive 0, ctrl[5] for drive 1), the strobe lasts 6 minus the code in ctrl[9:8] clocks, so 00 gives 6 and 11 gives 3. A fast drive without sample-enable uses 6.
- R6: For a fast drive, recovery lasts 8 minus the code in ctrl[12:10] clocks for codes 0 to 5, and 3 clocks for codes 6 and 7.
- R7: If IORDY is low at the sample clock, the strobe stays high. It drops, and `done` pulses, in the cycle after the first edge that sees IORDY high.
- R8: The strobe opens in the cycle after acceptance. `rd_strobe` or `wr_strobe` follows the request direction. `done` is a single-cycle pulse in the first recovery cycle, and `busy` is high from the strobe through the last recovery cycle.
- R9: A request that arrives while `busy` is high is not started until the recovery gap has ended, even though it decodes as a hit.
- R10: Bits ctrl[7:6] and ctrl[15:13] have no effect on decode or timing.
- R11: During and right after reset, `busy`, `done` and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host I/O request present |
| req_addr | input | 16 | Host I/O address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_drive | input | 1 | Target drive number |
| ctrl_word | input | 16 | Channel, per-drive timing enables, sample and recovery codes |
| iordy | input | 1 | Device ready line |
| hit | output | 1 | Request address claimed by the enabled channel |
| rd_strobe | output | 1 | Read command strobe |
| wr_strobe | output | 1 | Write command strobe |
| done | output | 1 | One-cycle pulse when an access completes |
| busy | output | 1 | Access or recovery in progress |

## Verification
The hardest condition to reach is a second request that shows up in the middle of a live cycle. It must see `hit` high and still be refused until the recovery count runs out. The bench produces this by issuing two accesses back to back, so the second arrives during the first one's strobe and is held across the whole recovery gap. It also holds IORDY low through the sample clock to stretch a strobe. A behavioural model predicts every output on every cycle across these sequences.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

    localparam int ADDR_W   = 16;
    localparam int CNT_W    = 4;
    localparam int NUM_DRV  = 2;
    localparam int DRV_W    = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1;
    localparam int SLOW_SMP = 6;
    localparam int SLOW_REC = 8;
    localparam int MIN_REC  = 3;
    localparam int REC_SAT  = 5;

    localparam logic [ADDR_W-1:0] PRI_CMD = 16'h01F0;
    localparam logic [ADDR_W-1:0] PRI_AUX = 16'h03F6;
    localparam logic [ADDR_W-1:0] SEC_CMD = 16'h0170;
    localparam logic [ADDR_W-1:0] SEC_AUX = 16'h0376;

    typedef enum logic [1:0] {
        CH_OFF = 2'b00,
        CH_PRI = 2'b01,
        CH_SEC = 2'b10,
        CH_RSV = 2'b11
    } chan_e;

    typedef struct packed {
        logic [2:0]         rsv_hi;
        logic [2:0]         rec_code;
        logic [1:0]         smp_code;
        logic [1:0]         rsv_lo;
        logic [NUM_DRV-1:0] smp_en;
        logic [NUM_DRV-1:0] fast_en;
        chan_e              chan;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic [CNT_W-1:0] smp;
        logic [CNT_W-1:0] rec;
    } timing_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STROBE,
        ST_WAIT,
        ST_RECOVER
    } state_e;

    function automatic logic [CNT_W-1:0] smp_clocks(input logic [1:0] code);
        return CNT_W'(SLOW_SMP) - CNT_W'(code);
    endfunction

    function automatic logic [CNT_W-1:0] rec_clocks(input logic [2:0] code);
        if (code >= 3'(REC_SAT))
            return CNT_W'(MIN_REC);
        return CNT_W'(SLOW_REC) - CNT_W'(code);
    endfunction

endpackage

// File: rtl/ide_addr_decode.sv
module ide_addr_decode
    import ide_pio_pkg::*;
(
    input  chan_e             chan,
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic pri_cmd, pri_aux, sec_cmd, sec_aux;

    // Primary command block spans 8 ports, secondary spans 16; both aux blocks span 2.
    assign pri_cmd = (addr[ADDR_W-1:3] == PRI_CMD[ADDR_W-1:3]);
    assign pri_aux = (addr[ADDR_W-1:1] == PRI_AUX[ADDR_W-1:1]);
    assign sec_cmd = (addr[ADDR_W-1:4] == SEC_CMD[ADDR_W-1:4]);
    assign sec_aux = (addr[ADDR_W-1:1] == SEC_AUX[ADDR_W-1:1]);

    always_comb begin
        unique case (chan)
            CH_PRI:  hit = valid && (pri_cmd || pri_aux);
            CH_SEC:  hit = valid && (sec_cmd || sec_aux);
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/ide_timing_select.sv
module ide_timing_select
    import ide_pio_pkg::*;
(
    input  logic [NUM_DRV-1:0] fast_en,
    input  logic [NUM_DRV-1:0] smp_en,
    input  logic [1:0]         smp_code,
    input  logic [2:0]         rec_code,
    input  logic [DRV_W-1:0]   drive,
    output timing_t            tim
);
    timing_t per_drv [NUM_DRV];

    for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
        always_comb begin
            per_drv[d].smp = (fast_en[d] && smp_en[d]) ? smp_clocks(smp_code)
                                                       : CNT_W'(SLOW_SMP);
            per_drv[d].rec = fast_en[d] ? rec_clocks(rec_code) : CNT_W'(SLOW_REC);
        end
    end

    always_comb begin
        tim = per_drv[0];
        for (int d = 1; d < NUM_DRV; d++)
            if (drive == DRV_W'(d))
                tim = per_drv[d];
    end
endmodule

// File: rtl/ide_cycle_fsm.sv
module ide_cycle_fsm
    import ide_pio_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    is_write,
    input  timing_t tim,
    input  logic    iordy,
    output logic    rd_strobe,
    output logic    wr_strobe,
    output logic    done,
    output logic    busy
);
    state_e           state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] rec_q;
    logic [CNT_W-1:0] smp_q;
    logic             wr_q;
    logic             active;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            rec_q <= '0;
            smp_q <= '0;
            wr_q  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_STROBE;
                        cnt   <= CNT_W'(1);
                        smp_q <= tim.smp;
                        rec_q <= tim.rec;
                        wr_q  <= is_write;
                    end
                end
                ST_STROBE: begin
                    if (cnt != smp_q) begin
                        cnt <= cnt + CNT_W'(1);
                    end else if (iordy) begin
                        state <= ST_RECOVER;
                        cnt   <= rec_q;
                        done  <= 1'b1;
                    end else begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (iordy) begin
                        state <= ST_RECOVER;
                        cnt   <= rec_q;
                        done  <= 1'b1;
                    end
                end
                ST_RECOVER: begin
                    if (cnt == CNT_W'(1))
                        state <= ST_IDLE;
                    else
                        cnt <= cnt - CNT_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign active    = (state == ST_STROBE) || (state == ST_WAIT);
    assign rd_strobe = active && !wr_q;
    assign wr_strobe = active && wr_q;
    assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/ide_pio_timer.sv
module ide_pio_timer
    import ide_pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DRV_W-1:0]  req_drive,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              iordy,
    output logic              hit,
    output logic              rd_strobe,
    output logic              wr_strobe,
    output logic              done,
    output logic              busy
);
    ctrl_t   cfg;
    timing_t tim;
    logic    start;
    logic    unused_rsv;

    assign cfg        = ctrl_t'(ctrl_word);
    assign unused_rsv = &{1'b0, cfg.rsv_hi, cfg.rsv_lo};

    ide_addr_decode u_dec (
        .chan  (cfg.chan),
        .valid (req_valid),
        .addr  (req_addr),
        .hit   (hit)
    );

    ide_timing_select u_tsel (
        .fast_en  (cfg.fast_en),
        .smp_en   (cfg.smp_en),
        .smp_code (cfg.smp_code),
        .rec_code (cfg.rec_code),
        .drive    (req_drive),
        .tim      (tim)
    );

    assign start = hit && !busy;

    ide_cycle_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .is_write  (req_write),
        .tim       (tim),
        .iordy     (iordy),
        .rd_strobe (rd_strobe),
        .wr_strobe (wr_strobe),
        .done      (done),
        .busy      (busy)
    );
endmodule

// File: rtl/ide_pio_timer_chk.sv
module ide_pio_timer_chk (
    input logic clk,
    input logic rst,
    input logic iordy,
    input logic hit,
    input logic rd_strobe,
    input logic wr_strobe,
    input logic done,
    input logic busy
);
    logic stb;
    assign stb = rd_strobe || wr_strobe;

    assert_reset_quiet_R11: assert property (@(posedge clk)
        rst |=> (!busy && !done && !stb));

    assert_start_needs_hit_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(stb) |-> $past(hit));

    assert_start_from_idle_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(stb) |-> !$past(busy));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_strobe_in_busy_R8: assert property (@(posedge clk) disable iff (rst)
        stb |-> busy);

    assert_done_closes_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!stb && $past(stb)));

    assert_hold_while_not_ready_R7: assert property (@(posedge clk) disable iff (rst)
        (stb && !iordy) |=> !done);
endmodule

bind ide_pio_timer ide_pio_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .iordy     (iordy),
    .hit       (hit),
    .rd_strobe (rd_strobe),
    .wr_strobe (wr_strobe),
    .done      (done),
    .busy      (busy)
);

// File: tb/ide_pio_timer_bench.sv
module ide_pio_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [15:0] req_addr;
    logic        req_write;
    logic [0:0]  req_drive;
    logic [15:0] ctrl_word;
    logic        iordy;
    logic        hit, rd_strobe, wr_strobe, done, busy;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    cmp_en   = 0;
    bit    finished = 0;
    string cur_req  = "R11";

    // behavioural model state: 0 idle, 1 strobe, 2 wait for ready, 3 recovery
    int m_phase = 0;
    int m_left  = 0;
    int m_rec   = 0;
    bit m_done  = 0;
    bit m_wr    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ide_pio_timer u_ide_pio_timer (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_drive(req_drive), .ctrl_word(ctrl_word),
        .iordy(iordy), .hit(hit), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
        .done(done), .busy(busy)
    );

    function automatic bit exp_hit(input bit v, input logic [15:0] c, input logic [15:0] a);
        if (!v) return 0;
        case (c[1:0])
            2'b01:   return (a >= 16'h1F0 && a <= 16'h1F7) || a == 16'h3F6 || a == 16'h3F7;
            2'b10:   return (a >= 16'h170 && a <= 16'h17F) || a == 16'h376 || a == 16'h377;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_smp(input logic [15:0] c, input int d);
        if (c[2+d] && c[4+d]) return 6 - int'(c[9:8]);
        return 6;
    endfunction

    function automatic int exp_rec(input logic [15:0] c, input int d);
        int code = int'(c[12:10]);
        if (!c[2+d]) return 8;
        if (code >= 5) return 3;
        return 8 - code;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0;
            m_done  = 0;
        end else begin
            m_done = 0;
            case (m_phase)
                0: if (exp_hit(req_valid, ctrl_word, req_addr)) begin
                       m_phase = 1;
                       m_left  = exp_smp(ctrl_word, int'(req_drive));
                       m_rec   = exp_rec(ctrl_word, int'(req_drive));
                       m_wr    = req_write;
                   end
                1, 2: begin
                       if (m_phase == 1 && m_left > 1) m_left--;
                       else if (iordy) begin
                           m_phase = 3; m_left = m_rec; m_done = 1;
                       end else m_phase = 2;
                   end
                3: if (m_left == 1) m_phase = 0; else m_left--;
                default: m_phase = 0;
            endcase
        end
    end

    task automatic check_bit(input string what, input logic act, input bit exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #(CLK_PERIOD/4);
        if (cmp_en) begin
            check_bit("hit", hit, exp_hit(req_valid, ctrl_word, req_addr));
            check_bit("rd_strobe", rd_strobe, (m_phase == 1 || m_phase == 2) && !m_wr);
            check_bit("wr_strobe", wr_strobe, (m_phase == 1 || m_phase == 2) && m_wr);
            check_bit("done", done, m_done);
            check_bit("busy", busy, m_phase != 0);
        end
    end

    task automatic access(input logic [15:0] c, input logic [15:0] a, input bit d, input bit w);
        bit acc;
        @(negedge clk);
        ctrl_word = c; req_addr = a; req_drive = d; req_write = w; req_valid = 1'b1;
        do begin
            acc = (m_phase == 0) && exp_hit(1'b1, c, a);
            @(negedge clk);
        end while (!acc);
        req_valid = 1'b0;
    endtask

    task automatic miss(input logic [15:0] c, input logic [15:0] a);
        @(negedge clk);
        ctrl_word = c; req_addr = a; req_valid = 1'b1; req_write = 1'b0; req_drive = 1'b0;
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_phase != 0);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
        req_drive = 1'b0; ctrl_word = '0; iordy = 1'b1;
        @(posedge clk);
        cmp_en = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;                                   // R11 reset state checked above
        repeat (2) @(negedge clk);

        cur_req = "R1";
        miss(16'h0000, 16'h01F0);
        miss(16'h0003, 16'h01F0);
        miss(16'h0003, 16'h0170);
        miss(16'h003C, 16'h0376);

        cur_req = "R2";
        miss(16'h0001, 16'h01F8);
        miss(16'h0001, 16'h03F5);
        miss(16'h0001, 16'h0170);
        access(16'h0001, 16'h01F0, 0, 0); wait_idle();
        access(16'h0001, 16'h01F7, 1, 1); wait_idle();
        access(16'h0001, 16'h03F6, 0, 1); wait_idle();
        access(16'h0001, 16'h03F7, 0, 0); wait_idle();

        cur_req = "R3";
        miss(16'h0002, 16'h0180);
        miss(16'h0002, 16'h01F0);
        miss(16'h0002, 16'h0378);
        access(16'h0002, 16'h0170, 0, 0); wait_idle();
        access(16'h0002, 16'h017F, 1, 1); wait_idle();
        access(16'h0002, 16'h0376, 0, 0); wait_idle();
        access(16'h0002, 16'h0377, 1, 0); wait_idle();

        cur_req = "R4";   // drive 1 slow, drive 0 fast, same codes
        access(16'h0001 | 16'h0014 | (16'd3 << 8) | (16'd5 << 10), 16'h01F2, 1, 0); wait_idle();
        access(16'h0001 | 16'h0014 | (16'd3 << 8) | (16'd5 << 10), 16'h01F2, 0, 0); wait_idle();
        access(16'h0001 | 16'h0004 | (16'd3 << 8), 16'h01F2, 0, 1); wait_idle();

        cur_req = "R5";
        for (int s = 0; s < 4; s++) begin
            access(16'h0002 | 16'h0028 | 16'(s << 8), 16'h0171, 1, 1);
            wait_idle();
        end

        cur_req = "R6";
        for (int r = 0; r < 8; r++) begin
            access(16'h0001 | 16'h0004 | 16'(r << 10), 16'h01F3, 0, 0);
            wait_idle();
        end

        cur_req = "R7";
        iordy = 1'b0;
        access(16'h0001, 16'h01F1, 0, 0);
        repeat (10) @(negedge clk);
        iordy = 1'b1;
        wait_idle();
        access(16'h0001 | 16'h0014 | (16'd3 << 8), 16'h01F1, 0, 1);
        iordy = 1'b0;
        @(negedge clk);
        iordy = 1'b1;
        wait_idle();

        cur_req = "R8";
        access(16'h0002 | 16'h0008, 16'h0172, 1, 1); wait_idle();

        cur_req = "R9";
        access(16'h0001 | 16'h0004 | (16'd7 << 10), 16'h01F4, 0, 1);
        access(16'h0001, 16'h01F5, 0, 0);
        access(16'h0001 | 16'h0014, 16'h03F6, 0, 1);
        wait_idle();

        cur_req = "R10";
        miss(16'hE0C0, 16'h01F0);
        access(16'hE0C0 | 16'h0001 | 16'h0014 | (16'd2 << 8) | (16'd4 << 10), 16'h01F6, 0, 0);
        wait_idle();
        access(16'hFFFE, 16'h0175, 1, 1);
        wait_idle();

        finished = 1;
        summary();
        $finish;
    end
endmodule